// File: doc/BRIEF.md
# Float-to-Integer Converter

This block turns a single-precision IEEE-754 value into a 32-bit integer. A per-operation select picks a two's-complement signed or a plain unsigned result. The rounding direction comes from a 2-bit mode input, or is forced toward zero by a truncate input, which serves C-style casts. Next to the integer the block returns three exception flags: the operand was subnormal, the conversion was invalid (out of range, or negative into unsigned), and the result is inexact.

Operations enter on a valid/ready stream and results leave on a second valid/ready stream through a single result register. `in_ready` is high when the result register is empty or is being drained in the same cycle, so one conversion per cycle is sustained when `out_ready` stays high. A result is visible on the cycle after its operation is accepted. While `out_valid` is high and `out_ready` is low, the integer and flags are held unchanged and no new operation is accepted.

Top module: `f2i_cvt`

## Requirements
- R1: `out_denorm` is 1 exactly when the accepted operand has a zero exponent field and a nonzero fraction. It is raised together with whatever the other flags report.
- R2: For a biased exponent of 159 or above, `out_invalid` is 1. A signed result is 0x7FFFFFFF for sign 0 and 0x80000000 for sign 1. An unsigned result is 0xFFFFFFFF for sign 0 and 0 for sign 1. For unsigned results a NaN counts as sign 0.
- R3: For biased exponents 126 to 158 the integer part of the magnitude is kept. `out_inexact` is 1 when any discarded fraction bit is nonzero and the result was not saturated or forced to zero.
- R4: Mode `in_rmode`=00 rounds to nearest. A discarded fraction above one half rounds up, and an exact half rounds to the even integer.
- R5: Mode 01 (toward +inf) adds one to the magnitude of a positive value with a nonzero discarded fraction. Mode 10 (toward -inf) does the same for a negative value. Mode 11 drops the fraction.
- R6: When `in_truncate`=1 the mode input is ignored and the result equals that of mode 11.
- R7: An unsigned conversion of a negative non-NaN value always returns 0. `out_invalid` is 1 whenever the magnitude would have rounded to a nonzero integer.
- R8: A signed magnitude above 0x7FFFFFFF for positive values, or above 0x80000000 for negative values, saturates to 0x7FFFFFFF or 0x80000000 with `out_invalid`=1. Otherwise a negative value is returned negated.
- R9: For biased exponents below 126 the result is 0, with `out_inexact`=1 if the operand is nonzero. Exceptions: a positive value in mode 01 gives 1. A negative value in mode 10 gives 0xFFFFFFFF for signed, or 0 with `out_invalid`=1 for unsigned.
- R10: An operation accepted on a clock edge (`in_valid` and `in_ready` both high) shows `out_valid`=1 on the next cycle. While `out_valid`=1 and `out_ready`=0 the integer and flags do not change.
- R11: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Operation will be taken on this edge |
| in_fp | input | 32 | Single-precision operand |
| in_signed | input | 1 | 1: signed result, 0: unsigned result |
| in_truncate | input | 1 | Force rounding toward zero |
| in_rmode | input | 2 | 00 nearest-even, 01 toward +inf, 10 toward -inf, 11 toward zero |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_int | output | 32 | Converted integer |
| out_denorm | output | 1 | Operand was subnormal |
| out_invalid | output | 1 | Conversion out of range or sign not representable |
| out_inexact | output | 1 | Result differs from the operand value |

## Verification
A wrong shift amount or a mis-split fraction shows in the very next result as an integer off by a power of two, or as a spurious or missing inexact flag. A wrong rounding increment shows only on operands whose discarded bits sit at or around one half, so ties and near-ties are aimed at directly. A flaw in the output register appears as a changed integer or a dropped `out_valid` during the first stalled cycle.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  localparam int FP_W   = 32;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int INT_W  = 32;
  localparam int BIAS   = 127;
  // derived exponent thresholds
  localparam int SAT_EXP = BIAS + INT_W;       // first exponent that cannot fit
  localparam int TOP_EXP = BIAS + INT_W - 1;   // shift of zero
  localparam int MIN_EXP = BIAS - 1;           // smallest exponent of the main path
  localparam int PAD_W   = INT_W - 1 - MAN_W;  // zero bits below the fraction

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_UP   = 2'b01,
    RM_DOWN = 2'b10,
    RM_ZERO = 2'b11
  } rmode_t;

  typedef struct packed {
    logic [INT_W-1:0] value;
    logic             denorm;
    logic             invalid;
    logic             inexact;
  } f2i_res_t;
endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
  import f2i_pkg::*;
(
  input  logic [FP_W-1:0]  fp,
  input  logic             to_signed,
  output logic             sgn,
  output logic [EXP_W-1:0] exp_b,
  output logic [INT_W-1:0] mag,
  output logic             nonzero,
  output logic             denorm
);
  logic [MAN_W-1:0] frac;
  logic             hidden;
  logic             is_nan;

  assign exp_b   = fp[FP_W-2 -: EXP_W];
  assign frac    = fp[MAN_W-1:0];
  assign hidden  = |exp_b;
  assign is_nan  = (&exp_b) & (|frac);
  // an unsigned conversion sees every NaN as positive
  assign sgn     = fp[FP_W-1] & ~(is_nan & ~to_signed);
  // magnitude with the leading one at the top bit of the integer width
  assign mag     = {hidden, frac, {PAD_W{1'b0}}};
  assign nonzero = hidden | (|frac);
  assign denorm  = ~hidden & (|frac);
endmodule

// File: rtl/f2i_round.sv
module f2i_round
  import f2i_pkg::*;
(
  input  logic             sgn,
  input  logic [EXP_W-1:0] exp_b,
  input  logic [INT_W-1:0] mag,
  input  logic             nonzero,
  input  rmode_t           rm,
  input  logic             to_signed,
  output logic [INT_W-1:0] value,
  output logic             invalid,
  output logic             inexact
);
  localparam int SH_W = $clog2(2 * INT_W);
  localparam logic [INT_W-1:0] ALL_ONES = {INT_W{1'b1}};
  localparam logic [INT_W-1:0] LIM_POS  = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] LIM_NEG  = {1'b1, {(INT_W-1){1'b0}}};

  logic [SH_W-1:0]    shamt;
  logic [2*INT_W-1:0] split;
  logic [INT_W-1:0]   ipart;
  logic [INT_W-1:0]   rem;
  logic [INT_W-1:0]   incr;
  logic [INT_W:0]     rsum;
  logic               carry;
  logic [INT_W-1:0]   dr;
  logic [INT_W-1:0]   lim;
  logic               in_sat;
  logic               in_main;

  assign in_sat  = int'(exp_b) >= SAT_EXP;
  assign in_main = int'(exp_b) >= MIN_EXP;
  assign shamt   = SH_W'(TOP_EXP - int'(exp_b));
  // integer part on top, remainder left-aligned below it
  assign split   = {mag, {INT_W{1'b0}}} >> shamt;
  assign ipart   = split[2*INT_W-1:INT_W];
  assign rem     = split[INT_W-1:0];

  always_comb begin
    case (rm)
      RM_NEAR: incr = {ipart[0], {(INT_W-1){~ipart[0]}}};
      RM_UP:   incr = sgn ? '0 : ALL_ONES;
      RM_DOWN: incr = sgn ? ALL_ONES : '0;
      default: incr = '0;
    endcase
  end

  assign rsum  = {1'b0, rem} + {1'b0, incr};
  assign carry = rsum[INT_W];

  always_comb begin
    value   = '0;
    invalid = 1'b0;
    inexact = 1'b0;
    dr      = ipart;
    lim     = sgn ? LIM_NEG : LIM_POS;
    if (in_sat) begin
      invalid = 1'b1;
      if (to_signed) value = lim;
      else           value = sgn ? '0 : ALL_ONES;
    end else if (in_main) begin
      if (!to_signed) begin
        if (carry) begin
          if (ipart != ALL_ONES) dr = ipart + 1'b1;
          else                   invalid = 1'b1;
        end
        if (sgn && dr != '0) begin
          invalid = 1'b1;
        end else begin
          value = dr;
          if (rem != '0) inexact = 1'b1;
        end
      end else begin
        if (carry && ipart != ALL_ONES) dr = ipart + 1'b1;
        if (dr > lim) begin
          dr      = lim;
          invalid = 1'b1;
        end else if (rem != '0) begin
          inexact = 1'b1;
        end
        value = sgn ? (~dr + 1'b1) : dr;
      end
    end else if (nonzero) begin
      inexact = 1'b1;
      if (rm == RM_UP && !sgn) begin
        value = {{(INT_W-1){1'b0}}, 1'b1};
      end else if (rm == RM_DOWN && sgn) begin
        if (to_signed) value = ALL_ONES;
        else           invalid = 1'b1;
      end
    end
  end
endmodule

// File: rtl/f2i_outreg.sv
module f2i_outreg #(
  parameter int W = 35
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/f2i_cvt.sv
module f2i_cvt
  import f2i_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [FP_W-1:0]  in_fp,
  input  logic             in_signed,
  input  logic             in_truncate,
  input  logic [1:0]       in_rmode,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [INT_W-1:0] out_int,
  output logic             out_denorm,
  output logic             out_invalid,
  output logic             out_inexact
);
  localparam int RES_W = $bits(f2i_res_t);

  logic             u_sgn;
  logic [EXP_W-1:0] u_exp;
  logic [INT_W-1:0] u_mag;
  logic             u_nonzero;
  logic             u_denorm;
  rmode_t           eff_rm;
  f2i_res_t         res_d;
  f2i_res_t         res_q;
  logic [RES_W-1:0] res_q_bits;

  assign eff_rm = in_truncate ? RM_ZERO : rmode_t'(in_rmode);

  f2i_unpack u_unpack (
    .fp        (in_fp),
    .to_signed (in_signed),
    .sgn       (u_sgn),
    .exp_b     (u_exp),
    .mag       (u_mag),
    .nonzero   (u_nonzero),
    .denorm    (u_denorm)
  );

  f2i_round u_round (
    .sgn       (u_sgn),
    .exp_b     (u_exp),
    .mag       (u_mag),
    .nonzero   (u_nonzero),
    .rm        (eff_rm),
    .to_signed (in_signed),
    .value     (res_d.value),
    .invalid   (res_d.invalid),
    .inexact   (res_d.inexact)
  );
  assign res_d.denorm = u_denorm;

  f2i_outreg #(.W(RES_W)) u_outreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (res_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (res_q_bits)
  );

  assign res_q       = f2i_res_t'(res_q_bits);
  assign out_int     = res_q.value;
  assign out_denorm  = res_q.denorm;
  assign out_invalid = res_q.invalid;
  assign out_inexact = res_q.inexact;
endmodule

// File: rtl/f2i_cvt_chk.sv
module f2i_cvt_chk
  import f2i_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [FP_W-1:0]  in_fp,
  input logic             in_signed,
  input logic             in_truncate,
  input logic [1:0]       in_rmode,
  input logic             out_valid,
  input logic             out_ready,
  input logic [INT_W-1:0] out_int,
  input logic             out_denorm,
  input logic             out_invalid,
  input logic             out_inexact
);
  logic [FP_W-1:0]  cap_fp;
  logic             cap_signed;
  logic [EXP_W-1:0] cap_exp;
  logic [MAN_W-1:0] cap_frac;
  logic             cap_nan;
  logic [3:0]       unused_ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_fp     <= '0;
      cap_signed <= 1'b0;
    end else if (in_valid && in_ready) begin
      cap_fp     <= in_fp;
      cap_signed <= in_signed;
    end
  end

  assign cap_exp    = cap_fp[FP_W-2 -: EXP_W];
  assign cap_frac   = cap_fp[MAN_W-1:0];
  assign cap_nan    = (&cap_exp) & (|cap_frac);
  assign unused_ctl = {in_truncate, in_rmode, out_inexact};

  a_r1_denorm_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_denorm == (cap_exp == '0 && cap_frac != '0));

  a_r2_saturate_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && int'(cap_exp) >= SAT_EXP) |-> out_invalid);

  a_r7_unsigned_negative: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !cap_signed && cap_fp[FP_W-1] && !cap_nan) |-> out_int == '0);

  a_r8_positive_signed: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_signed && !cap_fp[FP_W-1]) |-> !out_int[INT_W-1]);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_int)
      && $stable({out_denorm, out_invalid, out_inexact})));

  a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

bind f2i_cvt f2i_cvt_chk u_chk (.*);

// File: tb/f2i_cvt_test.sv
`timescale 1ns/1ps
module f2i_cvt_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_fp = '0;
  logic        in_signed = 1'b0;
  logic        in_truncate = 1'b0;
  logic [1:0]  in_rmode = 2'b00;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_int;
  logic        out_denorm, out_invalid, out_inexact;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  f2i_cvt uut (.*);

  // {value, denorm, invalid, inexact} from the requirements
  function automatic logic [34:0] model(input logic [31:0] fp, input bit sg,
                                        input bit tr, input logic [1:0] rmi);
    bit          s = fp[31];
    int          e = int'(fp[30:23]);
    logic [22:0] f = fp[22:0];
    logic [1:0]  rm = tr ? 2'b11 : rmi;
    longint      m, ip, rb, half, mg, lim;
    bit          up, den, inv, inx;
    logic [31:0] v;
    v = '0; inv = 0; inx = 0;
    den = (e == 0) && (f != 0);
    if (e == 255 && f != 0 && !sg) s = 0;
    if (e >= 159) begin
      inv = 1;
      if (sg) v = s ? 32'h8000_0000 : 32'h7fff_ffff;
      else    v = s ? 32'h0 : 32'hffff_ffff;
    end else if (e >= 126) begin
      m = longint'({1'b1, f});
      if (e >= 150) begin
        ip = m <<< (e - 150); rb = 0; half = 1;
      end else begin
        ip = m >>> (150 - e);
        rb = m & ((64'sd1 <<< (150 - e)) - 1);
        half = 64'sd1 <<< (149 - e);
      end
      case (rm)
        2'b00:   up = (rb > half) || (rb == half && ip[0]);
        2'b01:   up = (rb != 0) && !s;
        2'b10:   up = (rb != 0) && s;
        default: up = 0;
      endcase
      mg = ip + longint'(up);
      if (!sg) begin
        if (s && mg != 0) inv = 1;
        else begin v = mg[31:0]; inx = (rb != 0); end
      end else begin
        lim = s ? 64'sd2147483648 : 64'sd2147483647;
        if (mg > lim) begin
          inv = 1; v = s ? 32'h8000_0000 : 32'h7fff_ffff;
        end else begin
          inx = (rb != 0);
          v = s ? 32'(-mg) : mg[31:0];
        end
      end
    end else if (e != 0 || f != 0) begin
      inx = 1;
      if (rm == 2'b01 && !s) v = 32'd1;
      else if (rm == 2'b10 && s) begin
        if (sg) v = 32'hffff_ffff; else inv = 1;
      end
    end
    return {v, den, inv, inx};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [34:0] got, input logic [34:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic run(input string tag, input logic [31:0] fp, input bit sg,
                     input bit tr, input logic [1:0] rm, input int stall);
    logic [34:0] exp = model(fp, sg, tr, rm);
    @(negedge clk);
    in_fp = fp; in_signed = sg; in_truncate = tr; in_rmode = rm;
    in_valid = 1'b1;
    out_ready = (stall == 0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10", "valid after accept", {34'd0, out_valid}, 35'd1);
    check(tag, "result", {out_int, out_denorm, out_invalid, out_inexact}, exp);
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      check("R10", "held under stall",
            {out_int, out_denorm, out_invalid, out_inexact} & {35{out_valid}}, exp);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check("R10", "drained", {34'd0, out_valid}, 35'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R11", "idle after reset", {33'd0, out_valid, in_ready}, 35'b01);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "idle after release", {33'd0, out_valid, in_ready}, 35'b01);

    run("R3",  32'h4070_0000, 1, 0, 2'b11, 0); // 3.75 -> 3
    run("R3",  32'h4b7f_ffff, 0, 0, 2'b00, 0); // exact
    run("R4",  32'h3fc0_0000, 1, 0, 2'b00, 0); // 1.5 -> 2
    run("R4",  32'h4020_0000, 1, 0, 2'b00, 0); // 2.5 -> 2
    run("R4",  32'h3f00_0000, 0, 0, 2'b00, 0); // 0.5 -> 0
    run("R5",  32'h3fc0_0000, 1, 0, 2'b01, 0); // 1.5 -> 2
    run("R5",  32'hbfc0_0000, 1, 0, 2'b10, 0); // -1.5 -> -2
    run("R5",  32'hbfc0_0000, 1, 0, 2'b01, 0); // -1.5 -> -1
    run("R6",  32'h3fc0_0000, 1, 1, 2'b00, 0); // truncate -> 1
    run("R6",  32'hbfc0_0000, 1, 1, 2'b10, 0); // truncate -> -1
    run("R2",  32'h4f80_0000, 0, 0, 2'b00, 0);
    run("R2",  32'h4f80_0000, 1, 0, 2'b00, 0);
    run("R2",  32'hcf80_0000, 1, 0, 2'b00, 0);
    run("R2",  32'hcf80_0000, 0, 0, 2'b00, 0);
    run("R2",  32'hffc0_0000, 0, 0, 2'b00, 0); // NaN unsigned positive
    run("R8",  32'hcf00_0000, 1, 0, 2'b00, 0); // -2^31 exact
    run("R8",  32'h4f00_0000, 1, 0, 2'b00, 0); // 2^31 saturates
    run("R8",  32'h4f00_0000, 0, 0, 2'b00, 0); // fits unsigned
    run("R7",  32'hbf80_0000, 0, 0, 2'b00, 0); // -1.0 unsigned
    run("R7",  32'hbe80_0000, 0, 0, 2'b00, 0); // -0.25 unsigned
    run("R1",  32'h0000_0001, 1, 0, 2'b01, 0); // denormal, +inf -> 1
    run("R9",  32'h8000_0001, 0, 0, 2'b10, 0); // -inf unsigned invalid
    run("R9",  32'h8000_0001, 1, 0, 2'b10, 0); // -inf signed -> -1
    run("R9",  32'h3e80_0000, 1, 0, 2'b00, 0); // 0.25 -> 0
    run("R9",  32'h0000_0000, 1, 0, 2'b01, 0); // zero exact
    run("R10", 32'h4140_0000, 1, 0, 2'b00, 3); // stalled result

    for (int i = 0; i < 400; i++) begin
      logic [7:0]  ex;
      logic [31:0] fp;
      case ($urandom % 4)
        0, 1:    ex = 8'(120 + ($urandom % 46));
        2:       ex = 8'($urandom);
        default: ex = (($urandom % 2) == 0) ? 8'd0 : 8'd255;
      endcase
      fp = {1'($urandom), ex, 23'($urandom)};
      run("R3", fp, 1'($urandom), (($urandom % 4) == 0), 2'($urandom), int'($urandom % 3));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule